// File: doc/BRIEF.md
# Two-Stage Transponder Load Modulator

This block produces the load-switch control of a low-frequency contactless transponder. Each field clock it decides whether the coil load is switched on. A serial data stream is taken one bit at a time. A bitrate divider sets how many field clocks each bit lasts. A first coding stage turns the bit into a line-coded level. A second stage places that level on a phase-shifted or frequency-shifted subcarrier, or passes it through unchanged.

The two stages can be combined freely, apart from a small set of combinations that cannot work with the subcarrier timing. The block flags those combinations, together with the reserved codes, and keeps the load off while such a combination is selected. A one-clock bit-request strobe tells the data source when the next bit is taken. The configuration inputs are expected to be static while the block runs; they are changed only during reset.

Top module: `lf_tag_modulator`

## Requirements
- R1: `rate_sel_i` selects the bit period in field clocks: 0→8, 1→16, 2→32, 3→40, 4→50, 5→64, 6→100, 7→128. `bit_req_o` is high for exactly one clock, on the last clock of every bit period. The first bit period starts on the first clock after reset is released.
- R2: `data_bit_i` is captured on the clock edge that ends a cycle in which `bit_req_o` is high, and that bit is sent during the next bit period. With `line_sel_i`=00 and `sub_sel_i`=000, `load_on_o` equals the current bit for its whole period.
- R3: With `line_sel_i`=01 (Manchester), the first half of a bit period carries the inverted bit and the second half carries the bit. This gives a rising mid-bit edge for a 1 and a falling mid-bit edge for a 0.
- R4: With `line_sel_i`=10 (biphase), the stage-1 level inverts at every bit boundary. For a 1 it inverts again at mid-bit, that is at clock P/2 of the period.
- R5: With `sub_sel_i`=001, the output is the carrier XOR a phase bit. The phase bit toggles in the same clock in which the stage-1 level differs from its value in the previous clock.
- R6: With `sub_sel_i`=010, the phase bit toggles at a bit boundary when the stage-1 level was 1 in the last clock of the ending bit. The change takes effect from the first clock of the new bit.
- R7: With `sub_sel_i`=011, the phase bit toggles in the clock in which the stage-1 level rises from 0 to 1.
- R8: `car_sel_i` selects a PSK carrier period C of 2 (00), 4 (01) or 8 (10) clocks. The carrier is 1 while (clock index within the bit mod C) < C/2, so every bit starts at the same carrier phase.
- R9: For `sub_sel_i` 100, 101, 110 and 111, stage-1 level 1 uses a subcarrier period of 8, 8, 5 and 10 clocks respectively, and level 0 uses 5, 10, 8 and 8. Within a subcarrier period of D clocks the output is 1 for the first floor(D/2) clocks.
- R10: The FSK subcarrier counter returns to phase 0 at every bit boundary, so the first clock of every bit has the output high.
- R11: `cfg_err_o` is 1 when any of these holds: `line_sel_i`=11; or a PSK mode (001, 010, 011) is selected and either `car_sel_i`=11, or the bit period is not a multiple of C, or Manchester or biphase is combined with PSK2, or Manchester or biphase is combined with any PSK at period 8 with C=8.
- R12: While `cfg_err_o` is 1, `load_on_o` stays 0.
- R13: During reset `bit_req_o` is 0, and the first bit sent after reset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_bit_i | input | 1 | Next serial data bit, captured at the end of a strobe cycle |
| rate_sel_i | input | 3 | Bitrate code |
| line_sel_i | input | 2 | Stage-1 coding code |
| sub_sel_i | input | 3 | Stage-2 subcarrier code |
| car_sel_i | input | 2 | PSK carrier period code |
| bit_req_o | output | 1 | One-clock bit-request strobe |
| load_on_o | output | 1 | Load-switch enable |
| cfg_err_o | output | 1 | Unsupported or reserved configuration |

## Verification
The bench sweeps every bitrate against every stage-1 code. Each of these pairs is combined with direct coding, all three PSK modes at each carrier code, and all four FSK modes, and a pseudo-random bit stream is sent for three bit periods per setting. Periods 40, 50 and 100 set the multiple-of-carrier rule apart from plain power-of-two division. The mixed bit stream separates the Manchester polarity, the biphase mid-bit toggle and the three PSK phase rules, because each of them reacts differently to repeated ones, repeated zeros and transitions. Reserved carrier codes are also applied under non-PSK modes, which shows that the error rule fires only where the carrier is actually used.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

   localparam int unsigned MAX_PERIOD = 128;
   localparam int unsigned MAX_FSK_DIV = 10;

   typedef enum logic [1:0] {
      LC_DIRECT  = 2'b00,
      LC_MANCH   = 2'b01,
      LC_BIPHASE = 2'b10,
      LC_RSVD    = 2'b11
   } line_code_e;

   typedef enum logic [2:0] {
      SC_DIRECT = 3'b000,
      SC_PSK1   = 3'b001,
      SC_PSK2   = 3'b010,
      SC_PSK3   = 3'b011,
      SC_FSK_A  = 3'b100,
      SC_FSK_B  = 3'b101,
      SC_FSK_C  = 3'b110,
      SC_FSK_D  = 3'b111
   } sub_code_e;

   // Field clocks per data bit.
   function automatic int unsigned period_of(input logic [2:0] code);
      case (code)
         3'd0:    return 8;
         3'd1:    return 16;
         3'd2:    return 32;
         3'd3:    return 40;
         3'd4:    return 50;
         3'd5:    return 64;
         3'd6:    return 100;
         default: return 128;
      endcase
   endfunction

   // PSK carrier period, 0 for the reserved code.
   function automatic int unsigned carrier_of(input logic [1:0] code);
      case (code)
         2'd0:    return 2;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 0;
      endcase
   endfunction

   // FSK subcarrier period for a given mode and stage-1 level.
   function automatic int unsigned fsk_div(input logic [2:0] code, input logic lvl);
      case (code)
         3'b100:  return lvl ? 8  : 5;
         3'b101:  return lvl ? 8  : 10;
         3'b110:  return lvl ? 5  : 8;
         3'b111:  return lvl ? 10 : 8;
         default: return 8;
      endcase
   endfunction

endpackage

// File: rtl/lfm_bit_timer.sv
module lfm_bit_timer #(
   parameter int unsigned CNT_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] rate_sel_i,
   output logic [2:0] cnt_low_o,
   output logic       last_o,
   output logic       second_half_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_val;
   logic [CNT_W-1:0] half_val;

   always_comb begin
      last_val = CNT_W'(lfm_pkg::period_of(rate_sel_i) - 1);
      half_val = CNT_W'(lfm_pkg::period_of(rate_sel_i) >> 1);
   end

   assign last_o        = (cnt_q == last_val);
   assign second_half_o = (cnt_q >= half_val);
   assign cnt_low_o     = cnt_q[2:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (last_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/lfm_line_coder.sv
module lfm_line_coder (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_last_i,
   input  logic       second_half_i,
   input  logic       data_bit_i,
   input  logic [1:0] line_sel_i,
   output logic       s1_o
);

   import lfm_pkg::*;

   logic cur_q;   // bit being sent
   logic lvl_q;   // biphase level at the start of the bit
   line_code_e mode;

   assign mode = line_code_e'(line_sel_i);

   always_comb begin
      case (mode)
         LC_MANCH:   s1_o = second_half_i ? cur_q : ~cur_q;
         LC_BIPHASE: s1_o = second_half_i ? (lvl_q ^ cur_q) : lvl_q;
         default:    s1_o = cur_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= 1'b0;
         lvl_q <= 1'b0;
      end else if (bit_last_i) begin
         cur_q <= data_bit_i;
         // Level at the end of the bit, inverted at the boundary.
         lvl_q <= ~(lvl_q ^ cur_q);
      end
   end

endmodule

// File: rtl/lfm_subcarrier.sv
module lfm_subcarrier #(
   parameter int unsigned FSK_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] cnt_i,
   input  logic       bit_last_i,
   input  logic       s1_i,
   input  logic [2:0] sub_sel_i,
   input  logic [1:0] car_sel_i,
   output logic       sub_o
);

   import lfm_pkg::*;

   if (FSK_W < $clog2(MAX_FSK_DIV + 1)) begin : g_bad_fsk_w
      $error("FSK_W too narrow for the largest subcarrier period");
   end

   // Carrier taps: high for the first half of each carrier period.
   logic [2:0] taps;
   for (genvar gi = 0; gi < 3; gi++) begin : g_tap
      assign taps[gi] = ~cnt_i[gi];
   end

   logic carrier;
   always_comb begin
      case (car_sel_i)
         2'd1:    carrier = taps[1];
         2'd2:    carrier = taps[2];
         default: carrier = taps[0];
      endcase
   end

   sub_code_e mode;
   assign mode = sub_code_e'(sub_sel_i);

   // PSK phase tracking
   logic ph_q, s1_q, ph_now, ph_next;
   always_comb begin
      ph_now  = ph_q;
      ph_next = ph_q;
      case (mode)
         SC_PSK1: begin
            ph_now  = ph_q ^ (s1_i ^ s1_q);
            ph_next = ph_now;
         end
         SC_PSK2: begin
            ph_next = ph_q ^ (bit_last_i & s1_i);
         end
         SC_PSK3: begin
            ph_now  = ph_q ^ (s1_i & ~s1_q);
            ph_next = ph_now;
         end
         default: ;
      endcase
   end

   // FSK subcarrier
   logic [FSK_W-1:0] fc_q;
   logic [FSK_W-1:0] div;
   logic             fsk_out;
   assign div     = FSK_W'(fsk_div(sub_sel_i, s1_i));
   assign fsk_out = (fc_q < (div >> 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= 1'b0;
         s1_q <= 1'b0;
         fc_q <= '0;
      end else begin
         ph_q <= ph_next;
         s1_q <= s1_i;
         if (bit_last_i || (fc_q >= div - 1'b1)) begin
            fc_q <= '0;
         end else begin
            fc_q <= fc_q + 1'b1;
         end
      end
   end

   always_comb begin
      case (mode)
         SC_DIRECT:        sub_o = s1_i;
         SC_PSK1, SC_PSK3: sub_o = carrier ^ ph_now;
         SC_PSK2:          sub_o = carrier ^ ph_q;
         default:          sub_o = fsk_out;
      endcase
   end

endmodule

// File: rtl/lfm_cfg_check.sv
module lfm_cfg_check (
   input  logic [2:0] rate_sel_i,
   input  logic [1:0] line_sel_i,
   input  logic [2:0] sub_sel_i,
   input  logic [1:0] car_sel_i,
   output logic       err_o
);

   import lfm_pkg::*;

   always_comb begin
      int unsigned p;
      int unsigned c;
      logic is_psk;
      logic coded;
      p      = period_of(rate_sel_i);
      c      = carrier_of(car_sel_i);
      is_psk = (sub_sel_i == SC_PSK1) || (sub_sel_i == SC_PSK2) || (sub_sel_i == SC_PSK3);
      coded  = (line_sel_i == LC_MANCH) || (line_sel_i == LC_BIPHASE);
      err_o  = (line_sel_i == LC_RSVD);
      if (is_psk) begin
         if (c == 0) begin
            err_o = 1'b1;
         end else begin
            if ((p % c) != 0)                     err_o = 1'b1;
            if (coded && (sub_sel_i == SC_PSK2))  err_o = 1'b1;
            if (coded && (p == 8) && (c == 8))    err_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/lf_tag_modulator.sv
module lf_tag_modulator #(
   parameter int unsigned CNT_W   = 7,
   parameter int unsigned FSK_W   = 4,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       data_bit_i,
   input  logic [2:0] rate_sel_i,
   input  logic [1:0] line_sel_i,
   input  logic [2:0] sub_sel_i,
   input  logic [1:0] car_sel_i,
   output logic       bit_req_o,
   output logic       load_on_o,
   output logic       cfg_err_o
);

   if (CNT_W < $clog2(lfm_pkg::MAX_PERIOD)) begin : g_bad_cnt_w
      $error("CNT_W too narrow for the longest bit period");
   end

   logic [2:0] cnt_low;
   logic       bit_last;
   logic       second_half;
   logic       s1;
   logic       sub_out;
   logic       err;

   lfm_bit_timer #(.CNT_W(CNT_W)) u_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .rate_sel_i    (rate_sel_i),
      .cnt_low_o     (cnt_low),
      .last_o        (bit_last),
      .second_half_o (second_half)
   );

   lfm_line_coder u_stage1 (
      .clk           (clk),
      .rst_n         (rst_n),
      .bit_last_i    (bit_last),
      .second_half_i (second_half),
      .data_bit_i    (data_bit_i),
      .line_sel_i    (line_sel_i),
      .s1_o          (s1)
   );

   lfm_subcarrier #(.FSK_W(FSK_W)) u_stage2 (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_i      (cnt_low),
      .bit_last_i (bit_last),
      .s1_i       (s1),
      .sub_sel_i  (sub_sel_i),
      .car_sel_i  (car_sel_i),
      .sub_o      (sub_out)
   );

   lfm_cfg_check u_cfg (
      .rate_sel_i (rate_sel_i),
      .line_sel_i (line_sel_i),
      .sub_sel_i  (sub_sel_i),
      .car_sel_i  (car_sel_i),
      .err_o      (err)
   );

   assign bit_req_o = bit_last;
   assign cfg_err_o = err;

   if (OUT_REG) begin : g_out_reg
      logic load_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) load_q <= 1'b0;
         else        load_q <= sub_out & ~err;
      end
      assign load_on_o = load_q;
   end else begin : g_out_comb
      assign load_on_o = sub_out & ~err;
   end

endmodule

// File: rtl/lfm_checker.sv
module lfm_checker #(
   parameter bit OUT_REG = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] rate_sel_i,
   input logic [1:0] line_sel_i,
   input logic [2:0] sub_sel_i,
   input logic       bit_req_o,
   input logic       load_on_o,
   input logic       cfg_err_o
);

   logic [7:0] gap_q;
   logic       req_d1, req_d2, err_d1, load_prev, vld_q;
   logic       req_a, err_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q     <= '0;
         req_d1    <= 1'b0;
         req_d2    <= 1'b0;
         err_d1    <= 1'b0;
         load_prev <= 1'b0;
         vld_q     <= 1'b0;
      end else begin
         gap_q     <= bit_req_o ? 8'd0 : gap_q + 8'd1;
         req_d1    <= bit_req_o;
         req_d2    <= req_d1;
         err_d1    <= cfg_err_o;
         load_prev <= load_on_o;
         vld_q     <= 1'b1;
      end
   end

   // Align to the output latency.
   always_comb begin
      req_a = OUT_REG ? req_d2 : req_d1;
      err_a = OUT_REG ? err_d1 : cfg_err_o;
   end

   assert_req_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bit_req_o |-> (gap_q == 8'(lfm_pkg::period_of(rate_sel_i) - 1)));

   assert_direct_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((line_sel_i == 2'b00) && (sub_sel_i == 3'b000) && !cfg_err_o && vld_q && !req_a)
      |-> (load_on_o == load_prev));

   assert_biphase_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((line_sel_i == 2'b10) && (sub_sel_i == 3'b000) && !cfg_err_o && req_a)
      |-> (load_on_o != load_prev));

   assert_fsk_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_sel_i[2] && !cfg_err_o && req_a) |-> load_on_o);

   assert_mute_on_error_R12: assert property (@(posedge clk) disable iff (!rst_n)
      err_a |-> !load_on_o);

endmodule

bind lf_tag_modulator lfm_checker #(.OUT_REG(OUT_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rate_sel_i (rate_sel_i),
   .line_sel_i (line_sel_i),
   .sub_sel_i  (sub_sel_i),
   .bit_req_o  (bit_req_o),
   .load_on_o  (load_on_o),
   .cfg_err_o  (cfg_err_o)
);

// File: tb/lf_tag_modulator_tb_top.sv
module lf_tag_modulator_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 180000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       data_bit = 1'b0;
   logic [2:0] rate_sel = '0;
   logic [1:0] line_sel = '0;
   logic [2:0] sub_sel = '0;
   logic [1:0] car_sel = '0;
   logic       bit_req, load_on, cfg_err;

   int vectors = 0;
   int errors  = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   lf_tag_modulator dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .data_bit_i (data_bit),
      .rate_sel_i (rate_sel),
      .line_sel_i (line_sel),
      .sub_sel_i  (sub_sel),
      .car_sel_i  (car_sel),
      .bit_req_o  (bit_req),
      .load_on_o  (load_on),
      .cfg_err_o  (cfg_err)
   );

   function automatic int per(int r);
      case (r)
         0: return 8;   1: return 16;  2: return 32;  3: return 40;
         4: return 50;  5: return 64;  6: return 100; default: return 128;
      endcase
   endfunction

   function automatic int fskd(int s, bit b);
      case (s)
         4: return b ? 8 : 5;
         5: return b ? 8 : 10;
         6: return b ? 5 : 8;
         default: return b ? 10 : 8;
      endcase
   endfunction

   // R11 rule set
   function automatic bit err_exp(int r, int l, int s, int c);
      int cp;
      bit coded;
      if (l == 3) return 1'b1;
      if (s < 1 || s > 3) return 1'b0;
      if (c == 3) return 1'b1;
      cp = 2 << c;
      coded = (l == 1) || (l == 2);
      if ((per(r) % cp) != 0) return 1'b1;
      if (coded && s == 2) return 1'b1;
      if (coded && per(r) == 8 && cp == 8) return 1'b1;
      return 1'b0;
   endfunction

   function automatic string tag_of(bit e, int l, int s);
      if (e) return "R12";
      case (s)
         0: return (l == 1) ? "R3" : (l == 2) ? "R4" : "R2";
         1: return "R5,R8";
         2: return "R6,R8";
         3: return "R7,R8";
         default: return "R9,R10";
      endcase
   endfunction

   task automatic next_bit(output logic b);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr[0];
   endtask

   task automatic check(string tag, logic act, logic exp, int r, int l, int s, int c, int cyc);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s rate=%0d line=%0d sub=%0d car=%0d cyc=%0d: got %0b expected %0b",
                  tag, r, l, s, c, cyc, act, exp);
      end
   endtask

   task automatic run_cfg(int r, int l, int s, int c);
      int  pp, half, cp, d;
      int  m_cnt, m_fc;
      bit  m_bit, m_bp, m_ph, m_s1q;
      bit  e, sh, s1, car, ph_now, fo, exp_load, req;
      logic nb;
      @(negedge clk);
      rst_n    = 1'b0;
      rate_sel = 3'(r);
      line_sel = 2'(l);
      sub_sel  = 3'(s);
      car_sel  = 2'(c);
      next_bit(nb);
      data_bit = nb;
      repeat (2) @(negedge clk);
      e = err_exp(r, l, s, c);
      check("R13", bit_req, 1'b0, r, l, s, c, -1);
      check("R11", cfg_err, e, r, l, s, c, -1);
      pp = per(r); half = pp / 2;
      cp = (c == 3) ? 2 : (2 << c);
      m_cnt = 0; m_fc = 0; m_bit = 0; m_bp = 0; m_ph = 0; m_s1q = 0;
      rst_n = 1'b1;
      #1;
      for (int n = 0; n < 3 * pp; n++) begin
         sh = (m_cnt >= half);
         case (l)
            1: s1 = sh ? m_bit : !m_bit;
            2: s1 = sh ? (m_bp ^ m_bit) : m_bp;
            default: s1 = m_bit;
         endcase
         car = ((m_cnt % cp) < (cp / 2));        // R8 carrier locked to bit start
         case (s)
            1: ph_now = m_ph ^ (s1 ^ m_s1q);
            3: ph_now = m_ph ^ (s1 & !m_s1q);
            default: ph_now = m_ph;
         endcase
         d  = fskd(s, s1);
         fo = (m_fc < d / 2);
         if (e) exp_load = 1'b0;
         else if (s == 0) exp_load = s1;
         else if (s == 1 || s == 3) exp_load = car ^ ph_now;
         else if (s == 2) exp_load = car ^ m_ph;
         else exp_load = fo;
         req = (m_cnt == pp - 1);
         check("R1", bit_req, req, r, l, s, c, n);
         check(tag_of(e, l, s), load_on, exp_load, r, l, s, c, n);
         // advance the reference state to the next clock
         m_ph  = (s == 2) ? (m_ph ^ (req & s1)) : ph_now;
         m_s1q = s1;
         m_fc  = (req || m_fc >= d - 1) ? 0 : m_fc + 1;   // R10 restart
         if (req) begin
            m_bp  = !(m_bp ^ m_bit);
            m_bit = data_bit;
            m_cnt = 0;
         end else begin
            m_cnt++;
         end
         @(posedge clk);
         #1;
         if (req) begin
            next_bit(nb);
            data_bit = nb;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      for (int r = 0; r < 8; r++) begin
         for (int l = 0; l < 4; l++) begin
            for (int sp = 0; sp < 18; sp++) begin
               int s, c;
               if (sp == 0)       begin s = 0; c = 0; end
               else if (sp < 13)  begin s = 1 + (sp - 1) / 4; c = (sp - 1) % 4; end
               else if (sp < 17)  begin s = 4 + (sp - 13); c = 0; end
               else               begin s = 0; c = 3; end
               run_cfg(r, l, s, c);
            end
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule